// File: doc/BRIEF.md
# Token-Ring Functional Unit Issue Controller

This block sits between a column-split instruction queue and four functional units. Instructions arrive in groups of five, one per column. Each column shows only its oldest instruction, so once a column's head has been taken the next group's instruction in that column becomes visible. Each column also carries a 2-bit layer tag. The tag equals the number of instructions already taken from that column, modulo three.

Each functional unit has its own controller. A controller is a ring of fifteen cells, one for every column and layer pair. Every cell works out ahead of time what it would do if it held the token: issue, pass the token on, or wait. A single token walks the ring, visiting layer 0 columns 0..4, then layer 1 columns 0..4, then layer 2 columns 0..4, and then back to the start. The cell holding the token acts on its precomputed decision. As a result, each unit receives its own instructions strictly in program order across group boundaries, while different units advance independently of one another. Each token is kept as a toggle bit compared against the previous cell's toggle, so moving the token needs no return handshake.

An instruction word is 12 bits wide. Bits [11:10] name the target unit (0..3) and bits [9:0] are the payload forwarded to that unit.

Top module: `fu_issue_ring`

## Requirements
- R1: While reset is asserted, and with every column empty after reset, `col_ack` and `fu_valid` stay all zero, even if a column shows a valid instruction during reset.
- R2: A unit `u` only ever receives instructions whose bits [11:10] equal `u`. While `fu_valid[u]` is high, `fu_payload[u]` equals bits [9:0] of the column head being taken.
- R3: Each unit receives its instructions in program order: group by group, and within a group by ascending column. Every pushed instruction is eventually issued once units are ready.
- R4: `col_ack[c]` is high in exactly the cycles in which some unit takes column `c`'s head. It is high only while `col_valid[c]` is high, at most one unit takes a column in a given cycle, and every `fu_valid` pulse comes with exactly one matching column acknowledge in the same cycle.
- R5: An instruction is taken only in a cycle where its unit's `fu_ready` is high. While ready is low, the head is held with no acknowledge. In the first cycle ready is high again with the token still on it, the head is taken.
- R6: Each pass or issue moves the token one cell per clock. After reset the token of every controller sits on layer 0, column 0. Given the group F0,F0,F2,F2,F1 (columns 0..4), the issues occur in successive cycles 0..4 as u0/c0, u0/c1, u2/c2, u2/c3, u1/c4, and nothing follows.
- R7: A cell holding the token waits, and does not move it, when its column shows the previous layer, or when the column shows its own layer but is empty.
- R8: The layer tag `col_layer[c]` takes the values 0, 1 or 2 and equals the number of acknowledges of column `c` since reset, modulo 3. A column showing the cell's layer plus one (mod 3) makes the cell pass.
- R9: Different units can issue in the same cycle on different columns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| col_valid | input | 5 | Column head present |
| col_layer | input | 5x2 | Per-column layer tag, acknowledges modulo 3 |
| col_instr | input | 5x12 | Column head instruction: [11:10] unit, [9:0] payload |
| fu_ready | input | 4 | Functional unit can accept an instruction this cycle |
| col_ack | output | 5 | Column head taken this cycle |
| fu_valid | output | 4 | Instruction presented to the unit this cycle |
| fu_payload | output | 4x10 | Payload presented to each unit |

## Verification
The assertions assume a well-behaved column queue. A column's head and instruction stay stable until acknowledged, the layer tag counts acknowledges modulo three and never shows 3, and groups enter all five columns together. The bench meets these assumptions by modelling the queue itself: it pops a column only on an observed acknowledge, derives the layer from its own pop count, and pushes only whole groups. The random ready pattern leaves the order of issue between units free, while the model still checks each unit against its own program-order list.

// File: rtl/fuir_pkg.sv
package fuir_pkg;

  localparam int unsigned LAYERS = 3;

  typedef enum logic [1:0] {
    REL_THIS = 2'd0,
    REL_NEXT = 2'd1,
    REL_PREV = 2'd2,
    REL_BAD  = 2'd3
  } rel_e;

  // Position of the column's current layer relative to a cell's own layer.
  function automatic rel_e layer_rel(input logic [1:0] col_l, input logic [1:0] cell_l);
    logic [2:0] s;
    if (col_l == 2'd3) return REL_BAD;
    s = {1'b0, col_l} + 3'd3 - {1'b0, cell_l};
    if (s >= 3'd3) s = s - 3'd3;
    return rel_e'(s[1:0]);
  endfunction

endpackage

// File: rtl/ring_cell.sv
module ring_cell
  import fuir_pkg::*;
#(
  parameter logic [1:0] CELL_LAYER = 2'd0,
  parameter bit         ORIGIN     = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tok_in,
  input  logic       col_valid,
  input  logic [1:0] col_layer,
  input  logic       for_me,
  input  logic       unit_ready,
  output logic       tok_out,
  output logic       has_token,
  output logic       issue
);

  logic tok_q;
  logic pass;
  logic advance;
  rel_e rel;

  assign has_token = tok_in ^ tok_q ^ ORIGIN;
  assign tok_out   = tok_q;

  always_comb begin
    rel     = layer_rel(col_layer, CELL_LAYER);
    issue   = rst_n & has_token & (rel == REL_THIS) & col_valid & for_me & unit_ready;
    pass    = rst_n & has_token &
              (((rel == REL_THIS) & col_valid & ~for_me) | (rel == REL_NEXT));
    advance = issue | pass;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tok_q <= 1'b0;
    end else if (advance) begin
      tok_q <= ~tok_q;
    end
  end

  // R7: a column still in the previous layer keeps the token here.
  p_hold_on_prev_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (has_token && rel == REL_PREV) |=> has_token);

  // R8: a column already in the next layer never keeps the token.
  p_leave_on_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (has_token && rel == REL_NEXT) |=> !has_token);

endmodule

// File: rtl/unit_sequencer.sv
module unit_sequencer
  import fuir_pkg::*;
#(
  parameter int unsigned NCOL    = 5,
  parameter int unsigned PW      = 10,
  parameter int unsigned UW      = 2,
  parameter int unsigned UNIT_ID = 0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NCOL-1:0]          col_valid,
  input  logic [NCOL-1:0][1:0]     col_layer,
  input  logic [NCOL-1:0][UW-1:0]  col_unit,
  input  logic [NCOL-1:0][PW-1:0]  col_payload,
  input  logic                     unit_ready,
  output logic [NCOL-1:0]          col_issue,
  output logic                     fu_valid,
  output logic [PW-1:0]            fu_payload
);

  localparam int unsigned NCELL = NCOL * LAYERS;

  logic [NCELL-1:0] tok_q;
  logic [NCELL-1:0] has_tok;
  logic [NCELL-1:0] cell_issue;
  logic [NCOL-1:0]  for_me;

  always_comb begin
    for (int c = 0; c < NCOL; c++) begin
      for_me[c] = (col_unit[c] == UW'(UNIT_ID));
    end
  end

  for (genvar gl = 0; gl < LAYERS; gl++) begin : g_layer
    for (genvar gc = 0; gc < NCOL; gc++) begin : g_col
      localparam int unsigned IDX  = gl * NCOL + gc;
      localparam int unsigned PREV = (IDX == 0) ? NCELL - 1 : IDX - 1;
      ring_cell #(
        .CELL_LAYER (2'(gl)),
        .ORIGIN     (IDX == 0)
      ) u_cell (
        .clk        (clk),
        .rst_n      (rst_n),
        .tok_in     (tok_q[PREV]),
        .col_valid  (col_valid[gc]),
        .col_layer  (col_layer[gc]),
        .for_me     (for_me[gc]),
        .unit_ready (unit_ready),
        .tok_out    (tok_q[IDX]),
        .has_token  (has_tok[IDX]),
        .issue      (cell_issue[IDX])
      );
    end
  end

  always_comb begin
    col_issue  = '0;
    fu_payload = '0;
    for (int l = 0; l < LAYERS; l++) begin
      for (int c = 0; c < NCOL; c++) begin
        col_issue[c] = col_issue[c] | cell_issue[l*NCOL + c];
      end
    end
    for (int c = 0; c < NCOL; c++) begin
      if (col_issue[c]) fu_payload = fu_payload | col_payload[c];
    end
    fu_valid = |col_issue;
  end

  // R6: exactly one token lives in the ring at all times out of reset.
  p_single_token_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(has_tok) == 1);

  // R3: a unit takes at most one column per cycle.
  p_one_column_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(col_issue));

endmodule

// File: rtl/fu_issue_ring.sv
module fu_issue_ring
  import fuir_pkg::*;
#(
  parameter int unsigned NCOL  = 5,
  parameter int unsigned NUNIT = 4,
  parameter int unsigned PW    = 10,
  localparam int unsigned UW   = $clog2(NUNIT),
  localparam int unsigned IW   = PW + UW
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NCOL-1:0]          col_valid,
  input  logic [NCOL-1:0][1:0]     col_layer,
  input  logic [NCOL-1:0][IW-1:0]  col_instr,
  input  logic [NUNIT-1:0]         fu_ready,
  output logic [NCOL-1:0]          col_ack,
  output logic [NUNIT-1:0]         fu_valid,
  output logic [NUNIT-1:0][PW-1:0] fu_payload
);

  logic [1:0] rs_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rs_q[1];

  logic [NCOL-1:0][UW-1:0]     col_unit;
  logic [NCOL-1:0][PW-1:0]     col_payload;
  logic [NUNIT-1:0][NCOL-1:0]  take;
  logic [NCOL-1:0][NUNIT-1:0]  owner;

  always_comb begin
    for (int c = 0; c < NCOL; c++) begin
      col_unit[c]    = col_instr[c][IW-1:PW];
      col_payload[c] = col_instr[c][PW-1:0];
    end
  end

  for (genvar gu = 0; gu < NUNIT; gu++) begin : g_unit
    unit_sequencer #(
      .NCOL    (NCOL),
      .PW      (PW),
      .UW      (UW),
      .UNIT_ID (gu)
    ) u_seq (
      .clk         (clk),
      .rst_n       (rst_sync_n),
      .col_valid   (col_valid),
      .col_layer   (col_layer),
      .col_unit    (col_unit),
      .col_payload (col_payload),
      .unit_ready  (fu_ready[gu]),
      .col_issue   (take[gu]),
      .fu_valid    (fu_valid[gu]),
      .fu_payload  (fu_payload[gu])
    );

    // R5: no hand-off to a unit that is not ready.
    p_valid_needs_ready_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
      fu_valid[gu] |-> fu_ready[gu]);
  end

  always_comb begin
    for (int c = 0; c < NCOL; c++) begin
      for (int u = 0; u < NUNIT; u++) begin
        owner[c][u] = take[u][c];
      end
      col_ack[c] = |owner[c];
    end
  end

  for (genvar gc = 0; gc < NCOL; gc++) begin : g_colchk
    // R4: an acknowledge only for a present head.
    p_ack_needs_valid_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
      col_ack[gc] |-> col_valid[gc]);
    // R4: one taker per column per cycle.
    p_one_owner_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
      $onehot0(owner[gc]));
    // R2: the taker is the unit named in the instruction.
    p_owner_matches_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
      col_ack[gc] |-> owner[gc][col_unit[gc]]);
  end

endmodule

// File: tb/fu_issue_ring_tb.sv
module fu_issue_ring_tb;

  localparam int NCOL  = 5;
  localparam int NUNIT = 4;
  localparam int PW    = 10;
  localparam int IW    = 12;
  localparam int QD    = 512;
  localparam int ED    = 2048;

  logic clk;
  logic rst_n;
  logic [NCOL-1:0]          col_valid;
  logic [NCOL-1:0][1:0]     col_layer;
  logic [NCOL-1:0][IW-1:0]  col_instr;
  logic [NUNIT-1:0]         fu_ready;
  logic [NCOL-1:0]          col_ack;
  logic [NUNIT-1:0]         fu_valid;
  logic [NUNIT-1:0][PW-1:0] fu_payload;

  fu_issue_ring u_dut (
    .clk(clk), .rst_n(rst_n), .col_valid(col_valid), .col_layer(col_layer),
    .col_instr(col_instr), .fu_ready(fu_ready), .col_ack(col_ack),
    .fu_valid(fu_valid), .fu_payload(fu_payload)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int multi  = 0;

  logic [IW-1:0] qm [NCOL][QD];
  int qh [NCOL];
  int qt [NCOL];
  logic [PW-1:0] em [NUNIT][ED];
  int eh [NUNIT];
  int et [NUNIT];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive();
    for (int c = 0; c < NCOL; c++) begin
      col_valid[c] = (qh[c] < qt[c]);
      col_layer[c] = 2'(qh[c] % 3);
      col_instr[c] = (qh[c] < qt[c]) ? qm[c][qh[c] % QD] : '0;
    end
  endtask

  task automatic push_group(input logic [NCOL-1:0][1:0] us);
    for (int c = 0; c < NCOL; c++) begin
      logic [PW-1:0] p;
      p = PW'($urandom);
      qm[c][qt[c] % QD] = {us[c], p};
      qt[c]++;
      em[us[c]][et[us[c]] % ED] = p;
      et[us[c]]++;
    end
  endtask

  task automatic step(output logic [NCOL-1:0] a, output logic [NUNIT-1:0] v);
    @(negedge clk);
    a = col_ack;
    v = fu_valid;
    for (int u = 0; u < NUNIT; u++) begin
      if (v[u]) begin
        int nm;
        nm = 0;
        check(fu_ready[u], "R5", "valid without ready", 0, 1);
        for (int c = 0; c < NCOL; c++) begin
          if (a[c] && qh[c] < qt[c] && int'(qm[c][qh[c] % QD][IW-1:PW]) == u) begin
            nm++;
            check(fu_payload[u] == qm[c][qh[c] % QD][PW-1:0], "R2", "payload vs head",
                  int'(fu_payload[u]), int'(qm[c][qh[c] % QD][PW-1:0]));
          end
        end
        check(nm == 1, "R4", "matching acks per unit pulse", nm, 1);
        check(eh[u] < et[u] && fu_payload[u] == em[u][eh[u] % ED], "R3", "program order payload",
              int'(fu_payload[u]), int'(em[u][eh[u] % ED]));
        eh[u]++;
      end
    end
    for (int c = 0; c < NCOL; c++) begin
      if (a[c]) begin
        check(qh[c] < qt[c], "R4", "ack on empty column", qt[c] - qh[c], 1);
        if (qh[c] < qt[c]) begin
          int un;
          un = int'(qm[c][qh[c] % QD][IW-1:PW]);
          check(v[un], "R2", "ack without owner valid", int'(v[un]), 1);
          qh[c]++;
        end
      end
    end
    if ($countones(v) > 1) multi++;
    @(posedge clk);
    #1;
    drive();
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [NCOL-1:0] a;
    logic [NUNIT-1:0] v;
    logic [7:0][NCOL-1:0] exp_a;
    logic [7:0][NUNIT-1:0] exp_v;
    int groups;
    void'($urandom(32'd20240917));
    for (int c = 0; c < NCOL; c++) begin qh[c] = 0; qt[c] = 0; end
    for (int u = 0; u < NUNIT; u++) begin eh[u] = 0; et[u] = 0; end
    rst_n = 1'b0;
    fu_ready = '1;
    drive();
    // R1: a visible instruction during reset must not be taken
    col_valid[0] = 1'b1;
    col_layer[0] = 2'd0;
    col_instr[0] = {2'd0, 10'h155};
    repeat (3) begin
      @(negedge clk);
      check(col_ack == '0 && fu_valid == '0, "R1", "outputs during reset",
            int'({col_ack, fu_valid}), 0);
    end
    @(posedge clk);
    #1;
    drive();
    rst_n = 1'b1;
    // R1, R7: empty columns keep every token waiting
    for (int k = 0; k < 10; k++) begin
      step(a, v);
      check(a == '0 && v == '0, "R7", "idle with empty columns", int'({a, v}), 0);
    end
    // R6: exact cycles for group F0,F0,F2,F2,F1
    push_group({2'd1, 2'd2, 2'd2, 2'd0, 2'd0});
    drive();
    exp_a = {5'b0, 5'b0, 5'b0, 5'b10000, 5'b01000, 5'b00100, 5'b00010, 5'b00001};
    exp_v = {4'b0, 4'b0, 4'b0, 4'b0010, 4'b0100, 4'b0100, 4'b0001, 4'b0001};
    for (int k = 0; k < 8; k++) begin
      step(a, v);
      check(a == exp_a[k], "R6", $sformatf("ack in cycle %0d", k), int'(a), int'(exp_a[k]));
      check(v == exp_v[k], "R6", $sformatf("valid in cycle %0d", k), int'(v), int'(exp_v[k]));
    end
    // R5: hold with ready low, take on first ready cycle
    fu_ready = 4'b1011;
    push_group({2'd3, 2'd3, 2'd3, 2'd3, 2'd2});
    drive();
    for (int k = 0; k < 20; k++) begin
      step(a, v);
      check(!a[0] && !v[2], "R5", "column 0 held while unit 2 not ready", int'(a[0]), 0);
    end
    check(qh[0] < qt[0], "R5", "column 0 head still present", qt[0] - qh[0], 1);
    check(qh[4] == qt[4], "R8", "later columns of the group drained", qt[4] - qh[4], 0);
    fu_ready = '1;
    step(a, v);
    check(a[0] && v[2], "R5", "issue on first ready cycle", int'({a[0], v[2]}), 3);
    // R2, R3, R4, R8, R9: random groups and ready
    groups = 0;
    for (int k = 0; k < 4000; k++) begin
      if (groups < 150 && (qt[0] - qh[0]) < 6 && ($urandom % 3) != 0) begin
        logic [NCOL-1:0][1:0] us;
        for (int c = 0; c < NCOL; c++) us[c] = 2'($urandom);
        push_group(us);
        groups++;
      end
      for (int u = 0; u < NUNIT; u++) fu_ready[u] = (($urandom % 4) != 0);
      drive();
      step(a, v);
    end
    fu_ready = '1;
    drive();
    for (int k = 0; k < 400; k++) step(a, v);
    for (int c = 0; c < NCOL; c++)
      check(qh[c] == qt[c], "R3", $sformatf("column %0d drained", c), qt[c] - qh[c], 0);
    for (int u = 0; u < NUNIT; u++)
      check(eh[u] == et[u], "R3", $sformatf("unit %0d got all", u), eh[u], et[u]);
    check(multi > 0, "R9", "cycles with parallel issue", multi, 1);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule